// File: doc/BRIEF.md
# Scanline Prefetch Pixel Scanout

This block produces 640x480 raster timing from a 25 MHz pixel clock and streams the picture out of a small line FIFO. The FIFO is filled ahead of time with 16-bit framebuffer words. Each word carries two 8-bit palette indices. The words come from a memory that other users share, so the block asks an arbiter for one word address at a time. It issues these requests in short chunks whenever enough FIFO space is free. It accepts the returned words in the order they were requested and with any latency.

During active video one word leaves the FIFO at every even horizontal position. Its low byte is shown at that even pixel and its high byte at the odd pixel that follows. Outside the visible area the block holds blank high and drives a zero index. If the FIFO is empty when a pair is due, a sticky underflow flag is set.

At the end of every frame the fetch address returns to zero and the FIFO is flushed. Any word still in flight from the old frame is dropped when it arrives. As a result, leftovers from a damaged frame cannot shift the next one.

Top module: `scanline_pixel_scanout`

## Requirements
- R1: While reset is held, blank is 1, hsync_n and vsync_n are 1, pix_index is 0 and underflow is 0.
- R2: A line lasts H_FP+H_SYNC+H_BP+H_ACTIVE clocks. Counting from position 0 of the line, hsync_n is 0 for positions H_FP up to H_FP+H_SYNC-1. The last H_ACTIVE positions are visible.
- R3: A frame lasts V_FP+V_SYNC+V_BP+V_ACTIVE lines. vsync_n is 0 on lines V_FP up to V_FP+V_SYNC-1. The last V_ACTIVE lines are visible.
- R4: At every non-visible position, blank is 1 and pix_index is 0.
- R5: The visible pixel at column x of visible row y is byte (x mod 2) of word y*(H_ACTIVE/2)+x/2. Byte 0 is bits 7:0 and byte 1 is bits 15:8. All outputs are registered and appear one clock after the position they describe.
- R6: Request addresses start at 0 in each frame and go up by one per accepted request (req_valid and req_ready both 1 at a clock edge). A pending request holds its address until it is accepted. Exactly (H_ACTIVE/2)*V_ACTIVE requests are accepted per frame.
- R7: A chunk of CHUNK requests starts only when free space (DEPTH minus stored words minus words in flight) is at least CHUNK. Stored plus in-flight words never exceed DEPTH, so a long blank period prefetches exactly DEPTH words.
- R8: Returned words (rsp_valid) are taken in request order, whatever the latency and however ready is gapped, without changing the picture.
- R9: A pop that is due while the FIFO is empty sets underflow, which stays 1 until reset. In a run that keeps up, underflow stays 0.
- R10: At the last position of a frame, the FIFO is emptied and the fetch address returns to 0. Words requested before that point are discarded on return, so the following frame is shown correctly even after an underflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | pixel clock |
| rst | input | 1 | synchronous reset, active high |
| req_valid | output | 1 | a word fetch is requested |
| req_ready | input | 1 | arbiter takes the request this cycle |
| req_addr | output | AW | word address within the frame |
| rsp_valid | input | 1 | a fetched word is returned |
| rsp_data | input | 16 | returned word, two pixels |
| pix_index | output | 8 | palette index of the current pixel |
| hsync_n | output | 1 | horizontal sync, active low |
| vsync_n | output | 1 | vertical sync, active low |
| blank | output | 1 | 1 outside the visible area |
| underflow | output | 1 | sticky FIFO underflow flag |

## Verification
The bench uses a raster of 8x3 visible pixels, with porches and syncs of 2/2/2 clocks and 1/1/1 lines, an 8-word FIFO and 2-word chunks. A frame then lasts 84 clocks, and a run can cover several frames with every pixel checked against the address pattern. The 42-clock vertical blank is long enough for the FIFO to fill completely, which makes the DEPTH bound in R7 observable. The short visible line pops words at half the clock rate against a gapped ready signal with a latency of several cycles. A start with memory withheld forces underflow, so recovery across the frame flush can be observed.

// File: rtl/scanline_pixel_scanout.sv
module scanline_pixel_scanout #(
  parameter int H_ACTIVE = 640,
  parameter int H_FP     = 16,
  parameter int H_SYNC   = 96,
  parameter int H_BP     = 48,
  parameter int V_ACTIVE = 480,
  parameter int V_FP     = 10,
  parameter int V_SYNC   = 2,
  parameter int V_BP     = 33,
  parameter int DEPTH    = 64,
  parameter int CHUNK    = 8,
  parameter int AW       = $clog2((H_ACTIVE / 2) * V_ACTIVE + 1)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  input  logic          rsp_valid,
  input  logic [15:0]   rsp_data,
  output logic [7:0]    pix_index,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          blank,
  output logic          underflow
);

  localparam int HB = H_FP + H_SYNC + H_BP;
  localparam int HT = HB + H_ACTIVE;
  localparam int VB = V_FP + V_SYNC + V_BP;
  localparam int VT = VB + V_ACTIVE;
  localparam int FRAME_WORDS = (H_ACTIVE / 2) * V_ACTIVE;
  localparam int HW = $clog2(HT);
  localparam int VW = $clog2(VT);
  localparam int PW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(CHUNK + 1);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end, frame_end, in_active, pop, pop_ok;
  logic          in_hsync, in_vsync;

  assign line_end  = hcnt == HW'(HT - 1);
  assign frame_end = line_end && (vcnt == VW'(VT - 1));
  assign in_active = (hcnt >= HW'(HB)) && (vcnt >= VW'(VB));
  assign in_hsync  = (hcnt >= HW'(H_FP)) && (hcnt < HW'(H_FP + H_SYNC));
  assign in_vsync  = (vcnt >= VW'(V_FP)) && (vcnt < VW'(V_FP + V_SYNC));
  assign pop       = in_active && (hcnt[0] == 1'(HB % 2));

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt <= '0;
      vcnt <= '0;
    end else if (line_end) begin
      hcnt <= '0;
      vcnt <= frame_end ? '0 : vcnt + 1'b1;
    end else begin
      hcnt <= hcnt + 1'b1;
    end
  end

  // line FIFO, show-ahead from a register array
  logic [15:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] level, outst, stale, outst_nx;
  logic [LW:0]   free;
  logic          accept, push, empty;

  assign empty    = level == '0;
  assign pop_ok   = pop && !empty;
  assign accept   = req_valid && req_ready;
  assign push     = rsp_valid && (stale == '0) && !frame_end;
  assign outst_nx = outst + LW'(accept) - LW'(rsp_valid);
  assign free     = (LW+1)'(DEPTH) - {1'b0, level} - {1'b0, outst};

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= rsp_data;
  end

  always_ff @(posedge clk) begin
    if (rst || frame_end) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop_ok) rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      level <= level + LW'(push) - LW'(pop_ok);
    end
  end

  // fetch side: chunked requests, in-flight and stale accounting
  logic [AW-1:0] fcnt;
  logic [BW-1:0] burst_left;

  assign req_addr  = fcnt;
  assign req_valid = (fcnt != AW'(FRAME_WORDS)) &&
                     ((burst_left != '0) || (free >= (LW+1)'(CHUNK)));

  always_ff @(posedge clk) begin
    if (rst) begin
      outst      <= '0;
      stale      <= '0;
      fcnt       <= '0;
      burst_left <= '0;
    end else begin
      outst <= outst_nx;
      if (frame_end) begin
        stale      <= outst_nx;
        fcnt       <= '0;
        burst_left <= '0;
      end else begin
        if (rsp_valid && (stale != '0)) stale <= stale - 1'b1;
        if (accept) begin
          fcnt       <= fcnt + 1'b1;
          burst_left <= (burst_left == '0) ? BW'(CHUNK - 1) : burst_left - 1'b1;
        end
      end
    end
  end

  // registered pixel and sync outputs
  logic [7:0] hi_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_index <= '0;
      hi_q      <= '0;
      hsync_n   <= 1'b1;
      vsync_n   <= 1'b1;
      blank     <= 1'b1;
      underflow <= 1'b0;
    end else begin
      hsync_n <= !in_hsync;
      vsync_n <= !in_vsync;
      blank   <= !in_active;
      if (pop && empty) underflow <= 1'b1;
      if (!in_active) begin
        pix_index <= '0;
      end else if (pop) begin
        pix_index <= pop_ok ? mem[rp][7:0]  : 8'd0;
        hi_q      <= pop_ok ? mem[rp][15:8] : 8'd0;
      end else begin
        pix_index <= hi_q;
      end
    end
  end

endmodule

module scanline_pixel_scanout_chk #(
  parameter int DEPTH = 64,
  parameter int AW    = 18,
  parameter int LW    = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          blank,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic [7:0]    pix_index,
  input logic          underflow,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rsp_valid,
  input logic          push,
  input logic          frame_end,
  input logic [LW-1:0] level,
  input logic [LW-1:0] outst
);

  a_r4_blank_zero: assert property (@(posedge clk) disable iff (rst)
    blank |-> pix_index == 8'd0);

  a_r2_hsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> blank);

  a_r3_vsync_in_blank: assert property (@(posedge clk) disable iff (rst)
    !vsync_n |-> blank);

  a_r9_underflow_sticky: assert property (@(posedge clk) disable iff (rst)
    underflow |=> underflow);

  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready && !frame_end) |=> (req_valid && $stable(req_addr)));

  a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> level < LW'(DEPTH));

  a_r7_space_bound: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, level} + {1'b0, outst}) <= (LW+1)'(DEPTH));

  a_r8_rsp_expected: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> outst != '0);

endmodule

bind scanline_pixel_scanout scanline_pixel_scanout_chk #(
  .DEPTH(DEPTH), .AW(AW), .LW(LW)
) u_chk (
  .clk(clk), .rst(rst), .blank(blank), .hsync_n(hsync_n), .vsync_n(vsync_n),
  .pix_index(pix_index), .underflow(underflow), .req_valid(req_valid),
  .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .push(push), .frame_end(frame_end), .level(level), .outst(outst)
);

// File: tb/test_scanline_pixel_scanout.sv
module test_scanline_pixel_scanout;
  localparam int HA = 8, HFP = 2, HS = 2, HBP = 2;
  localparam int VA = 3, VFP = 1, VS = 1, VBP = 1;
  localparam int DEPTH = 8, CHUNK = 2;
  localparam int HB = HFP + HS + HBP, HT = HB + HA;
  localparam int VB = VFP + VS + VBP, VT = VB + VA;
  localparam int FT = HT * VT;
  localparam int FW = (HA / 2) * VA;
  localparam int AW = $clog2(FW + 1);
  localparam int FIRST_POP = VB * HT + HB;

  logic clk = 0, rst = 1;
  logic req_valid, req_ready = 0, rsp_valid = 0;
  logic [AW-1:0] req_addr;
  logic [15:0] rsp_data = 0;
  logic [7:0] pix_index;
  logic hsync_n, vsync_n, blank, underflow;

  scanline_pixel_scanout #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HS), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VS), .V_BP(VBP),
    .DEPTH(DEPTH), .CHUNK(CHUNK)
  ) i_scanline_pixel_scanout (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .pix_index(pix_index), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .blank(blank), .underflow(underflow)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0, total_cyc = 0;
  int cyc = 0, seed = 0, mode = 0, lat = 1, chk_from = 0;
  int exp_addr = 0, acc_cnt = 0;
  int q_addr[$], q_due[$];
  bit done = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cyc %0d)", req, act, expv, cyc);
    end
  endtask

  function automatic int pix(input int i);
    return (i * 37 + seed) & 255;
  endfunction

  function automatic bit rdy_fn(input int c);
    case (mode)
      1: return (c % 3) != 0;
      2: return c >= FIRST_POP + 4;
      default: return 1'b1;
    endcase
  endfunction

  always @(posedge clk) begin
    total_cyc <= total_cyc + 1;
    cyc <= rst ? 0 : cyc + 1;
  end

  always @(negedge clk) begin
    if (rst) begin
      req_ready = 0;
      rsp_valid = 0;
      q_addr.delete();
      q_due.delete();
      exp_addr = 0;
      acc_cnt = 0;
    end else begin
      if (cyc >= 1) begin
        int p, h, v, fr;
        p = cyc - 1; h = p % HT; v = (p / HT) % VT; fr = p / FT;
        if (fr >= chk_from) begin
          bit vis;
          vis = (h >= HB) && (v >= VB);
          check(blank == !vis, "R4 blank", blank, !vis);
          check(hsync_n == !(h >= HFP && h < HFP + HS), "R2 hsync_n", hsync_n,
                !(h >= HFP && h < HFP + HS));
          check(vsync_n == !(v >= VFP && v < VFP + VS), "R3 vsync_n", vsync_n,
                !(v >= VFP && v < VFP + VS));
          if (vis) check(pix_index == 8'(pix((v - VB) * HA + (h - HB))), "R5 pixel",
                         pix_index, pix((v - VB) * HA + (h - HB)));
          else check(pix_index == 0, "R4 pix zero", pix_index, 0);
        end
      end
      if (cyc % FT == 0) begin
        if (cyc > 0 && (cyc / FT - 1) >= chk_from)
          check(acc_cnt == FW, "R6 words per frame", acc_cnt, FW);
        acc_cnt = 0;
        exp_addr = 0;
      end
      if (cyc % FT == FIRST_POP && cyc / FT >= chk_from)
        check(acc_cnt == DEPTH, "R7 prefetch fill", acc_cnt, DEPTH);
      req_ready = rdy_fn(cyc);
      if (req_valid && req_ready) begin
        check(int'(req_addr) == exp_addr, "R6 address order", req_addr, exp_addr);
        q_addr.push_back(int'(req_addr));
        q_due.push_back(cyc + lat);
        exp_addr++;
        acc_cnt++;
      end
      if (q_due.size() > 0 && q_due[0] <= cyc) begin
        int a;
        a = q_addr.pop_front();
        void'(q_due.pop_front());
        rsp_valid = 1;
        rsp_data = {8'(pix(2 * a + 1)), 8'(pix(2 * a))};
      end else begin
        rsp_valid = 0;
      end
    end
  end

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(blank == 1, "R1 blank", blank, 1);
    check(hsync_n == 1 && vsync_n == 1, "R1 syncs", {hsync_n, vsync_n}, 3);
    check(pix_index == 0, "R1 pix", pix_index, 0);
    check(underflow == 0, "R1 underflow", underflow, 0);
    @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic t_steady(input int s, input int m, input int l, input int frames);
    seed = s; mode = m; lat = l; chk_from = 0;
    do_reset();
    repeat (frames * FT + 2) @(posedge clk);
    @(negedge clk);
    check(underflow == 0, "R9 no underflow (R8 latency run)", underflow, 0);
  endtask

  task automatic t_starve();
    seed = 91; mode = 2; lat = 3; chk_from = 1;
    do_reset();
    repeat (FT) @(posedge clk);
    @(negedge clk);
    check(underflow == 1, "R9 underflow set", underflow, 1);
    repeat (2 * FT) @(posedge clk);
    @(negedge clk);
    check(underflow == 1, "R9 underflow sticky", underflow, 1);
    // frames 1 and 2 checked pixel by pixel: R10 recovery after flush
  endtask

  initial begin
    t_steady(5, 0, 1, 3);
    t_steady(200, 1, 4, 3);
    t_steady(17, 1, 2, 2);
    t_starve();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    wait (total_cyc > 20000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", total_cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule